// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit fixed-point coefficients, several lanes at once. Each lane product is scaled down by 256 and rounded half-up to a 16-bit result. A 3-bit mode code picks how pixels and coefficients are drawn from two 64-bit operands, and how lane results are placed in the 64-bit result word.

Seven codes are defined:
- Per-lane coefficients.
- A single coefficient broadcast to every lane, taken from either half of the second operand's low word.
- Pixels taken from the high or low byte of each 16-bit lane of the first operand.
- A two-lane form that places each rounded result, shifted left by 7, inside its own 32-bit half.

The eighth code is reserved. A request is a single-cycle pulse. The result and its valid flag come out of a register one clock later.

Top module: `pmul8x16`

## Requirements
- R1: Each lane forms the product of an unsigned 8-bit pixel and a two's-complement 16-bit coefficient. Its result is product bits 23:8 plus product bit 7, kept to 16 bits (wrapping).
- R2: Mode 0 (per-lane): lane i (i = 0..3) uses pixel `op_a[8i+7:8i]` and coefficient `op_b[16i+15:16i]`. Its result lands at `res[16i+15:16i]`.
- R3: Mode 1 broadcasts coefficient `op_b[31:16]` and mode 2 broadcasts `op_b[15:0]` to all four lanes. Pixels and placement are as in mode 0.
- R4: Mode 3 takes pixel `op_a[16i+15:16i+8]` and mode 4 takes pixel `op_a[16i+7:16i]`. Both use coefficient `op_b[16i+15:16i]`, with results placed as in mode 0.
- R5: Mode 5 (high byte) and mode 6 (low byte) form two lanes, i = 0..1. Each lane uses the pixel byte of `op_a[16i+15:16i]` and coefficient `op_b[16i+15:16i]`. Its result goes to `res[32i+22:32i+7]`, and every other result bit is 0.
- R6: Mode 7 produces an all-zero result with `res_vld` still asserted.
- R7: `res_vld` rises in the cycle after a cycle with `req_vld` high. `res` carries that request's result from the same edge.
- R8: In a cycle with `req_vld` low, `res` holds its value and `res_vld` is low in the following cycle, whatever the other inputs do.
- R9: While reset is held, `res` is 0 and `res_vld` is 0.
- R10: `op_a[63:32]` has no effect in modes 0, 1, 2, 5 and 6. `op_b[63:32]` has no effect in modes 1, 2, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one per operation |
| mode | input | 3 | Operand selection and placement code (0..7) |
| op_a | input | 64 | Pixel operand |
| op_b | input | 64 | Coefficient operand |
| res_vld | output | 1 | Result valid, one cycle after the request |
| res | output | 64 | Registered lane results |

## Verification
Every result, including the zero of the reserved code, is due exactly one clock after the edge that captured its request. The driver raises `req_vld` just after a falling edge and files the expected word in a queue. The monitor samples at every falling edge and pops one entry each time `res_vld` is high, so each comparison lands in the cycle the result is due. An unexpected `res_vld` counts as a failure. Hold behaviour is checked by scrambling the inputs with `req_vld` low and comparing `res` to its last value.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
   typedef enum logic [2:0] {
      PM_LANE    = 3'd0,
      PM_BC_HI   = 3'd1,
      PM_BC_LO   = 3'd2,
      PM_SEL_HI  = 3'd3,
      PM_SEL_LO  = 3'd4,
      PM_WIDE_HI = 3'd5,
      PM_WIDE_LO = 3'd6,
      PM_RSVD    = 3'd7
   } pm_mode_e;

   function automatic logic is_wide(input pm_mode_e m);
      return (m == PM_WIDE_HI) || (m == PM_WIDE_LO);
   endfunction
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16
) (
   input  logic [PIX_W-1:0]  pix,
   input  logic [COEF_W-1:0] coef,
   output logic [COEF_W-1:0] frac
);
   localparam int PROD_W = PIX_W + COEF_W + 1;

   logic signed [PROD_W-1:0] full;

   always_comb begin
      full = $signed({1'b0, pix}) * $signed(coef);
      frac = full[PIX_W +: COEF_W] + COEF_W'(full[PIX_W-1]);
   end
endmodule

// File: rtl/pmul_opsel.sv
module pmul_opsel
   import pmul_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   localparam int DATA_W = LANES * COEF_W
) (
   input  pm_mode_e                       mode,
   input  logic [DATA_W-1:0]              op_a,
   input  logic [DATA_W-1:0]              op_b,
   output logic [LANES-1:0][PIX_W-1:0]    pix,
   output logic [LANES-1:0][COEF_W-1:0]   coef
);
   localparam int HI_OFS = COEF_W - PIX_W;

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         pix[i]  = op_a[PIX_W*i +: PIX_W];
         coef[i] = op_b[COEF_W*i +: COEF_W];
         unique case (mode)
            PM_BC_HI: coef[i] = op_b[COEF_W +: COEF_W];
            PM_BC_LO: coef[i] = op_b[0 +: COEF_W];
            PM_SEL_HI, PM_WIDE_HI: pix[i] = op_a[COEF_W*i + HI_OFS +: PIX_W];
            PM_SEL_LO, PM_WIDE_LO: pix[i] = op_a[COEF_W*i +: PIX_W];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pmul_place.sv
module pmul_place
   import pmul_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   localparam int DATA_W = LANES * COEF_W
) (
   input  pm_mode_e                     mode,
   input  logic [LANES-1:0][COEF_W-1:0] lane_res,
   output logic [DATA_W-1:0]            word
);
   localparam int HALF_W = 2 * COEF_W;
   localparam int WSHIFT = PIX_W - 1;

   always_comb begin
      word = '0;
      if (is_wide(mode)) begin
         for (int i = 0; i < LANES / 2; i++)
            word[HALF_W*i + WSHIFT +: COEF_W] = lane_res[i];
      end else if (mode != PM_RSVD) begin
         for (int i = 0; i < LANES; i++)
            word[COEF_W*i +: COEF_W] = lane_res[i];
      end
   end
endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
   import pmul_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   localparam int DATA_W = LANES * COEF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [2:0]        mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              res_vld,
   output logic [DATA_W-1:0] res
);
   localparam int HALF_W = 2 * COEF_W;
   localparam int WSHIFT = PIX_W - 1;

   function automatic logic [DATA_W-1:0] wide_gap_mask();
      logic [DATA_W-1:0] m;
      m = '1;
      for (int i = 0; i < LANES / 2; i++)
         m[HALF_W*i + WSHIFT +: COEF_W] = '0;
      return m;
   endfunction
   localparam logic [DATA_W-1:0] GAP_MASK = wide_gap_mask();

   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("pmul8x16: LANES must be even and at least 2");
      end
      if (COEF_W < PIX_W) begin : g_bad_widths
         $error("pmul8x16: COEF_W must not be narrower than PIX_W");
      end
      if (WSHIFT + COEF_W > HALF_W) begin : g_bad_wide
         $error("pmul8x16: wide placement exceeds its half");
      end
   endgenerate

   pm_mode_e                     mode_e;
   logic [LANES-1:0][PIX_W-1:0]  pix;
   logic [LANES-1:0][COEF_W-1:0] coef;
   logic [LANES-1:0][COEF_W-1:0] lane_res;
   logic [DATA_W-1:0]            word;

   assign mode_e = pm_mode_e'(mode);

   pmul_opsel #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_opsel (
      .mode (mode_e),
      .op_a (op_a),
      .op_b (op_b),
      .pix  (pix),
      .coef (coef)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         pmul_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_lane (
            .pix  (pix[g]),
            .coef (coef[g]),
            .frac (lane_res[g])
         );
      end
   endgenerate

   pmul_place #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_place (
      .mode     (mode_e),
      .lane_res (lane_res),
      .word     (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         res     <= '0;
      end else begin
         res_vld <= req_vld;
         if (req_vld)
            res <= word;
      end
   end

   // R7
   vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> res_vld);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!res_vld && $stable(res)));

   // R6
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && mode == 3'd7) |=> (res_vld && res == '0));

   // R5
   wide_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && (mode == 3'd5 || mode == 3'd6)) |=> ((res & GAP_MASK) == '0));

   // R1
   zero_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && mode == 3'd0 && op_a[PIX_W*LANES-1:0] == '0) |=> (res == '0));

   // R9
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_clear_chk: assert (res == '0 && !res_vld);
      end
   end
endmodule

// File: tb/tb_pmul8x16.sv
module tb_pmul8x16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        res_vld;
   logic [63:0] res;

   int checks = 0;
   int fails  = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];
   logic        done = 1'b0;

   always #2 clk = ~clk;

   pmul8x16 dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode),
      .op_a(op_a), .op_b(op_b), .res_vld(res_vld), .res(res)
   );

   function automatic logic [15:0] lane_ref(input logic [7:0] p, input logic [15:0] c);
      logic signed [31:0] prod;
      prod = $signed({24'd0, p}) * $signed({{16{c[15]}}, c});
      return prod[23:8] + {15'd0, prod[7]};
   endfunction

   function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] a,
                                         input logic [63:0] b);
      logic [63:0] r;
      r = '0;
      case (m)
         3'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[8*i +: 8], b[16*i +: 16]);
         3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[8*i +: 8], b[31:16]);
         3'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[8*i +: 8], b[15:0]);
         3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[16*i+8 +: 8], b[16*i +: 16]);
         3'd4: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[16*i +: 8], b[16*i +: 16]);
         3'd5: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = lane_ref(a[16*i+8 +: 8], b[16*i +: 16]);
         3'd6: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = lane_ref(a[16*i +: 8], b[16*i +: 16]);
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                        input string tag);
      @(negedge clk);
      req_vld = 1'b1;
      mode = m;
      op_a = a;
      op_b = b;
      exp_q.push_back(model(m, a, b));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         req_vld = 1'b0;
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_vld) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected res_vld", {63'd0, res_vld}, 64'd0);
         end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, res, e);
         end
      end
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 res in reset", res, 64'd0);
      check("R9 res_vld in reset", {63'd0, res_vld}, 64'd0);
      rst_n = 1'b1;
      idle(2);
      check("R9 res after reset", res, 64'd0);

      // R1: arithmetic corners
      issue(3'd0, 64'h0000_0000_FF00_FF00, 64'h8000_8000_8000_8000, "R1 max pix x min coef");
      issue(3'd0, 64'h0000_0000_0101_01FF, 64'h7FFF_0080_FF80_7FFF, "R1 rounding edges");
      issue(3'd0, 64'h0000_0000_8080_0180, 64'hFFFF_0001_0180_0001, "R1 negative rounding");

      // R7: latency of a lone request
      idle(1);
      issue(3'd0, 64'h0000_0000_1234_5678, 64'h1111_2222_3333_4444, "R7 lone request");
      @(negedge clk);
      req_vld = 1'b0;
      check("R7 res_vld one cycle after", {63'd0, res_vld}, 64'd1);
      @(negedge clk);
      check("R7 res_vld drops", {63'd0, res_vld}, 64'd0);

      // R8: hold with scrambled inputs
      held = res;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         mode = 3'(k);
         op_a = {$urandom, $urandom};
         op_b = {$urandom, $urandom};
      end
      @(negedge clk);
      check("R8 res held while idle", res, held);
      check("R8 res_vld low while idle", {63'd0, res_vld}, 64'd0);

      // R2..R6 directed
      issue(3'd0, 64'hDEAD_BEEF_0102_0304, 64'h0100_0200_0300_0400, "R2 per-lane");
      issue(3'd1, 64'h0000_0000_FF80_4001, 64'h1234_5678_C000_0001, "R3 broadcast high");
      issue(3'd2, 64'h0000_0000_FF80_4001, 64'h1234_5678_C000_7FFF, "R3 broadcast low");
      issue(3'd3, 64'hFF00_8000_0100_7F00, 64'h7FFF_8000_0100_FFFF, "R4 upper byte");
      issue(3'd4, 64'h00FF_0080_0001_007F, 64'h7FFF_8000_0100_FFFF, "R4 lower byte");
      issue(3'd5, 64'h0000_0000_FF00_8000, 64'h0000_0000_8000_7FFF, "R5 wide upper byte");
      issue(3'd6, 64'h0000_0000_00FF_0080, 64'h0000_0000_8000_7FFF, "R5 wide lower byte");
      issue(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R6 reserved code");

      // R10: unused upper halves have no effect
      issue(3'd0, 64'h0000_0000_A5A5_5A5A, 64'h1357_2468_ACE0_BDF1, "R10 mode0 a-high zero");
      issue(3'd0, 64'hFFFF_FFFF_A5A5_5A5A, 64'h1357_2468_ACE0_BDF1, "R10 mode0 a-high ones");
      issue(3'd5, 64'h1234_5678_A5A5_5A5A, 64'hFFFF_FFFF_ACE0_BDF1, "R10 mode5 high halves");
      issue(3'd6, 64'h0000_0000_A5A5_5A5A, 64'h0000_0000_ACE0_BDF1, "R10 mode6 high halves");
      issue(3'd1, 64'h8765_4321_A5A5_5A5A, 64'h0F0F_0F0F_ACE0_BDF1, "R10 mode1 high halves");
      idle(2);

      // Random back-to-back traffic across all codes
      for (int k = 0; k < 200; k++) begin
         issue(3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom},
               "R1-model random R2 R3 R4 R5 R6");
         if (k % 17 == 0) idle(1);
      end
      idle(3);
      check("R7 scoreboard drained", 64'(exp_q.size()), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule